// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output compare channel that sits beside a free-running timer counter. It holds a compare value and, while the timer runs, watches the counter. On the first cycle the counter equals the compare value, the channel raises its event flag and applies a pin action. Two configuration bits choose that action: set, clear, toggle, or leave the output alone. The flag can drive an interrupt request. Software clears the flag by writing a one to it.

A force strobe applies the configured pin action at once but never raises the flag. A disconnect bit lets software prepare the internal output register while the pin still shows a general-purpose port latch. Clearing the bit then hands the pin over to the channel with its start level already in place. The same port latch also drives the pin whenever the channel is not in output compare use.

Top module: `oc_channel`

## Requirements
- R1: While the select bit (configuration bit 0) is 0, neither a counter match nor a force strobe changes the flag or the internal output register. The pin shows the port latch.
- R2: While the timer enable is 1 and the select bit is 1, the flag is set one clock after the first cycle in which the counter equals the compare register. If the counter holds that value on later cycles, no new match occurs.
- R3: The interrupt output is 1 exactly when the flag is 1 and the interrupt enable (configuration bit 4) is 1.
- R4: With mode (configuration bit 2) and level (configuration bit 1) both 0, a match or a force leaves the internal output register unchanged.
- R5: With mode 0 and level 1, a match or a force inverts the internal output register on the following clock.
- R6: With mode 1, a match or a force sets the internal output register to the level bit on the following clock.
- R7: A force strobe applies the pin action only while the timer enable is 1 and the select bit is 1. A force strobe never sets the flag.
- R8: While the disconnect bit (configuration bit 3) is 1, compare actions still update the internal output register, but the pin shows the port latch. When the bit returns to 0, the pin shows the internal output register.
- R9: A port write only loads the port latch. It has no effect on the pin while the channel drives the pin (select 1, disconnect 0).
- R10: A flag clear strobe clears the flag only while the timer enable is 1. If a match sets the flag in the same cycle, the set wins.
- R11: Reset clears the flag, the internal output register, the port latch, the compare register and the configuration register.
- R12: While the timer enable is 0, no match is detected and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_en | input | 1 | Timer enable |
| cnt | input | 16 | Timer counter value |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare register write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration data {ie, disconnect, mode, level, select} |
| force_we | input | 1 | Force strobe |
| flag_clr_we | input | 1 | Flag clear strobe (write-one-to-clear) |
| port_we | input | 1 | Port latch write strobe |
| port_wdata | input | 1 | Port latch write data |
| flag | output | 1 | Channel event flag |
| irq | output | 1 | Interrupt request |
| pin | output | 1 | Channel pin |

## Verification
Suppose the internal output register holds a wrong value while the pin is disconnected or deselected. That fault stays hidden until the channel drives the pin again. The bench therefore reconnects the pin after each preload and compares the level on that cycle. A wrong match edge detector shows up one clock later, either as an early flag or a repeated toggle, so the bench holds the counter on the compare value for several cycles. A wrong flag shows on the flag and interrupt outputs one clock after the faulty update.

// File: rtl/oc_pkg.sv
// Package: shared types for the output compare channel.
// Assumes the configuration register is written as one packed word.
package oc_pkg;
    localparam int CFG_W = 5;

    // Pin action chosen by {mode, level}.
    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_act_e;

    // Configuration word; first member is the most significant bit.
    typedef struct packed {
        logic ie;
        logic pdis;
        logic mode;
        logic level;
        logic ios;
    } oc_cfg_t;
endpackage

// File: rtl/oc_match.sv
// Module: oc_match
// Produces a one-cycle hit on the first cycle the counter equals the
// compare value while enabled. Assumes the counter and compare are synchronous.
module oc_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    output logic         hit
);
    logic eq;
    logic eq_d;

    assign eq = (cnt == cmp);

    // Remember whether the previous cycle was an enabled equality.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_d <= 1'b0;
        else        eq_d <= en && eq;
    end

    assign hit = en && eq && !eq_d;
endmodule

// File: rtl/oc_action.sv
// Module: oc_action
// Holds the internal output register and applies the selected action
// when fired. Assumes fire is already qualified by select and enable.
module oc_action
    import oc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fire,
    input  oc_act_e act,
    output logic    out_q
);
    // Update the output register according to the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (fire) begin
            case (act)
                ACT_TOGGLE: out_q <= ~out_q;
                ACT_CLEAR:  out_q <= 1'b0;
                ACT_SET:    out_q <= 1'b1;
                default:    out_q <= out_q;
            endcase
        end
    end
endmodule

// File: rtl/oc_flag.sv
// Module: oc_flag
// Event flag with set priority over clear. Assumes set and clear are
// qualified by the caller.
module oc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Set wins; otherwise clear; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/oc_channel.sv
// Module: oc_channel (top)
// One output compare channel: compare/config/port registers, match
// detection, output action, flag, interrupt and pin multiplexing.
// Assumes the counter is supplied from outside on the same clock.
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             force_we,
    input  logic             flag_clr_we,
    input  logic             port_we,
    input  logic             port_wdata,
    output logic             flag,
    output logic             irq,
    output logic             pin
);
    logic [CNT_W-1:0] cmp_q;
    oc_cfg_t          cfg_q;
    logic             port_q;
    logic             hit;
    logic             fire;
    logic             out_q;
    logic             ios;
    logic             mode;
    logic             level;
    oc_act_e          act;

    // Compare and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            cfg_q <= '0;
        end else begin
            if (cmp_we) cmp_q <= cmp_wdata;
            if (cfg_we) cfg_q <= oc_cfg_t'(cfg_wdata);
        end
    end

    // General-purpose port latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       port_q <= 1'b0;
        else if (port_we) port_q <= port_wdata;
    end

    assign ios   = cfg_q.ios;
    assign mode  = cfg_q.mode;
    assign level = cfg_q.level;
    assign act   = oc_act_e'({mode, level});

    oc_match #(.W(CNT_W)) u_match (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tmr_en),
        .cnt  (cnt),
        .cmp  (cmp_q),
        .hit  (hit)
    );

    assign fire = ios && (hit || (force_we && tmr_en));

    oc_action u_action (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (fire),
        .act  (act),
        .out_q(out_q)
    );

    oc_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (hit && ios),
        .clr  (flag_clr_we && tmr_en),
        .flag (flag)
    );

    assign irq = flag && cfg_q.ie;
    assign pin = (ios && !cfg_q.pdis) ? out_q : port_q;
endmodule

// File: rtl/oc_channel_chk.sv
// Module: oc_channel_chk
// Property checker for oc_channel, attached with bind.
module oc_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic tmr_en,
    input logic force_we,
    input logic flag_clr_we,
    input logic hit,
    input logic ios,
    input logic mode,
    input logic level,
    input logic out_q,
    input logic flag
);
    assert_flag_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(ios));

    assert_hold_no_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !level) |=> $stable(out_q));

    assert_set_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ios && mode && level) |=> out_q);

    assert_force_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_we && !flag && !hit) |=> !flag);

    assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_we && tmr_en && !hit) |=> !flag);

    assert_idle_no_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> !$rose(flag));
endmodule

bind oc_channel oc_channel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_en     (tmr_en),
    .force_we   (force_we),
    .flag_clr_we(flag_clr_we),
    .hit        (hit),
    .ios        (ios),
    .mode       (mode),
    .level      (level),
    .out_q      (out_q),
    .flag       (flag)
);

// File: tb/oc_channel_bench.sv
module oc_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_en = 1'b0;
    logic [15:0] cnt = '0;
    logic        cmp_we = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_wdata = '0;
    logic        force_we = 1'b0;
    logic        flag_clr_we = 1'b0;
    logic        port_we = 1'b0;
    logic        port_wdata = 1'b0;
    logic        flag, irq, pin;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string cur_req = "R11";

    // reference model state
    bit [15:0] m_cmp;
    bit [4:0]  m_cfg;
    bit        m_out, m_flag, m_port, m_eqd;

    always #2 clk = ~clk;

    oc_channel u_oc_channel (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .cnt(cnt),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .force_we(force_we), .flag_clr_we(flag_clr_we),
        .port_we(port_we), .port_wdata(port_wdata),
        .flag(flag), .irq(irq), .pin(pin)
    );

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit hit, fire;
        if (!rst_n) begin
            m_cmp = 0; m_cfg = 0; m_out = 0; m_flag = 0; m_port = 0; m_eqd = 0;
        end else begin
            hit   = tmr_en && (cnt == m_cmp) && !m_eqd;
            m_eqd = tmr_en && (cnt == m_cmp);
            fire  = m_cfg[0] && (hit || (force_we && tmr_en));
            if (fire) begin
                if (m_cfg[2]) m_out = m_cfg[1];
                else if (m_cfg[1]) m_out = !m_out;
            end
            if (m_cfg[0] && hit) m_flag = 1;
            else if (flag_clr_we && tmr_en) m_flag = 0;
            if (cmp_we)  m_cmp  = cmp_wdata;
            if (cfg_we)  m_cfg  = cfg_wdata;
            if (port_we) m_port = port_wdata;
        end
    end

    // Compare all outputs against the model on every falling edge.
    always @(negedge clk) begin
        bit e_pin, e_irq;
        e_pin = (m_cfg[0] && !m_cfg[3]) ? m_out : m_port;
        e_irq = m_flag && m_cfg[4];
        vectors++;
        if (flag !== m_flag || irq !== e_irq || pin !== e_pin) begin
            miscompares++;
            $display("FAIL %s: flag/irq/pin actual %b%b%b expected %b%b%b at cycle %0d",
                     cur_req, flag, irq, pin, m_flag, e_irq, e_pin, cycles);
        end
        cycles++;
        if (cycles > 20000) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_we = 0; cfg_we = 0; force_we = 0; flag_clr_we = 0; port_we = 0;
        end
    endtask

    task automatic wr_cfg(bit ie, bit pdis, bit mode, bit level, bit ios);
        cfg_we = 1; cfg_wdata = {ie, pdis, mode, level, ios}; cyc();
    endtask
    task automatic wr_cmp(logic [15:0] v);
        cmp_we = 1; cmp_wdata = v; cyc();
    endtask
    task automatic wr_port(bit v);
        port_we = 1; port_wdata = v; cyc();
    endtask
    task automatic pulse_force(); force_we = 1; cyc(); endtask
    task automatic pulse_clr();   flag_clr_we = 1; cyc(); endtask
    task automatic run(logic [15:0] from, int n);
        cnt = from;
        for (int i = 0; i < n; i++) begin cyc(); cnt = cnt + 1; end
    endtask

    initial begin
        cyc(3);
        rst_n = 1;            // R11: reset state compared
        cyc(2);
        tmr_en = 1;

        cur_req = "R1";       // deselected: no flag, pin = port latch
        wr_cmp(16'd10);
        run(16'd5, 10);
        pulse_force();
        cur_req = "R9";
        wr_port(1'b1);
        cyc(2);

        cur_req = "R6";       // set action, flag, interrupt (R2, R3)
        wr_cfg(1, 0, 1, 1, 1);
        run(16'd7, 6);
        cur_req = "R9";       // port write ignored while driven
        wr_port(1'b0);
        cyc(2);

        cur_req = "R10";      // clear while enabled, ignored while disabled
        tmr_en = 0; pulse_clr(); cyc();
        tmr_en = 1; pulse_clr(); cyc();
        cnt = 16'd9; cyc(); cnt = 16'd10; flag_clr_we = 1; cyc(); cyc();

        cur_req = "R6";       // clear action
        pulse_clr();
        wr_cfg(0, 0, 1, 0, 1);
        run(16'd8, 5);

        cur_req = "R5";       // toggle, held counter matches once (R2)
        wr_cfg(1, 0, 0, 1, 1);
        cnt = 16'd9; cyc(); cnt = 16'd10; cyc(6);
        cnt = 16'd11; cyc(); cnt = 16'd10; cyc(3);
        pulse_clr();

        cur_req = "R4";       // no action
        wr_cfg(1, 0, 0, 0, 1);
        run(16'd8, 5);
        pulse_force();

        cur_req = "R7";       // force toggles without flag; gated
        pulse_clr();
        wr_cfg(1, 0, 0, 1, 1);
        cnt = 16'd100;
        pulse_force(); cyc();
        pulse_force(); cyc();
        tmr_en = 0; pulse_force(); cyc(); tmr_en = 1;
        wr_cfg(1, 0, 0, 1, 0); pulse_force(); cyc();

        cur_req = "R8";       // preload while disconnected
        wr_port(1'b0);
        wr_cfg(0, 1, 1, 0, 1); pulse_force(); cyc();
        wr_cfg(0, 1, 1, 1, 1); pulse_force(); cyc(2);
        wr_cfg(0, 0, 1, 1, 1); cyc(2);
        wr_cfg(0, 1, 1, 0, 1); run(16'd8, 5);
        wr_cfg(0, 0, 1, 0, 1); cyc(2);

        cur_req = "R12";      // disabled timer: no match
        pulse_clr();
        wr_cfg(1, 0, 0, 1, 1);
        tmr_en = 0; run(16'd8, 5);
        tmr_en = 1; cyc(2);

        cur_req = "R11";      // reset in mid-run
        rst_n = 0; cyc(2); rst_n = 1; cyc(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule